// File: doc/BRIEF.md
# Split Instruction/Data TLB Lookup with Permission Faults

This block holds two translation look-aside buffers, one serving instruction fetches and one serving data reads and writes. Each buffer has four ways of sixteen entries, and every entry is a pair of 32-bit words. The upper word carries a virtual page number and an owning process ID. The lower word carries a page frame number and five attribute flags. Software fills the entries through a plain register write port. No hardware walks page tables.

A lookup request gives a virtual address, an access type, a user-mode flag and the current process ID. The block reads the indexed entry from all four ways of the matching buffer in one cycle. It picks the lowest matching way. On a hit it applies the permission checks in fixed priority, and each check is gated by its own configuration enable. One cycle after the request it returns either a physical address with the entry's permission flags, or a fault with an exception vector. On any fault it records the faulting page, access type and process ID in a cause register, and the entry coordinates in a select register. On a miss the way offered for software refill comes from a 16-bit LFSR, and that LFSR advances only when a fault occurs.

Top module: `tlb_perm_checker`

## Requirements
- R1: A write stores `wr_hi`/`wr_lo` into the buffer chosen by `wr_itlb` (1 = instruction, 0 = data) at way `wr_way`, index `wr_idx`. A lookup in the same cycle as a write sees the old contents. Lookups in later cycles see the new contents.
- R2: The index is vaddr[16:13]. An entry hits when hi[31:13] equals vaddr[31:13] and either lo[4] (global) is set or hi[7:0] equals `req_pid`. Access code 2 (execute) uses the instruction buffer. Codes 0 (read), 1 (write) and 3 (treated as a read, reported as 0) use the data buffer.
- R3: Every request produces `rsp_vld` exactly one cycle later, and no response appears without a request. On a hit without a fault, `rsp_paddr` = {lo[31:13], vaddr[12:0]} and `rsp_perm` = lo[3:0] (valid, kernel, writable, executable).
- R4: When several ways hit, the lowest-numbered way supplies the result.
- R5: Hit checks apply in this order, and the first that fires wins. Kernel page (lo[2]) with `req_user` gives base+2. Write (code 1) to a page with lo[1] clear gives base+3. Execute (code 2) of a page with lo[0] clear gives base+3. A page with lo[3] clear gives base+1.
- R6: Each of those checks is active only when its `cfg` enable is set: bit 18 kernel, bit 19 write, bit 17 execute, bit 16 valid. With all four clear, every hit passes.
- R7: A miss faults with vector base+0. The base is 4 for the instruction buffer and 8 for the data buffer. A faulting response has `rsp_paddr` and `rsp_perm` zero.
- R8: The LFSR resets to 0xCCCC. On each fault it shifts right by one, and the new bit 15 is the parity of (state AND 0x8805). It holds on hits and idle cycles. A miss offers way = LFSR[1:0] as it stood before that fault.
- R9: On a fault `sel_reg` is loaded with the index in bits 3:0 and the way in bits 5:4. The way is the refill way on a miss and the hitting way on a permission fault. Without a fault it holds.
- R10: On a fault `cause_reg` is loaded with the faulting VPN in bits 31:13, the access code in bits 9:8, `req_pid` in bits 7:0, and zeros elsewhere. Without a fault it holds.
- R11: After reset `rsp_vld`, `sel_reg` and `cause_reg` are zero and every entry word is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Entry write strobe |
| wr_itlb | input | 1 | Write target: 1 instruction buffer, 0 data buffer |
| wr_way | input | 2 | Way to write |
| wr_idx | input | 4 | Index to write |
| wr_hi | input | 32 | Upper entry word (VPN, process ID) |
| wr_lo | input | 32 | Lower entry word (PFN, flags) |
| cfg | input | 32 | Check enables in bits 19:16 |
| req_vld | input | 1 | Lookup request |
| req_vaddr | input | 32 | Virtual address |
| req_acc | input | 2 | Access code: 0 read, 1 write, 2 execute, 3 read |
| req_user | input | 1 | Request made in user mode |
| req_pid | input | 8 | Current process ID |
| rsp_vld | output | 1 | Response valid, one cycle after request |
| rsp_fault | output | 1 | Response is a fault |
| rsp_vec | output | 4 | Exception vector on fault |
| rsp_paddr | output | 32 | Physical address on success |
| rsp_perm | output | 4 | Entry flags {valid, kernel, writable, executable} on success |
| sel_reg | output | 6 | Fault entry coordinates {way, index} |
| cause_reg | output | 32 | Fault cause {VPN, access code, process ID} |

## Verification
A table write and a lookup can land in the same cycle on the same entry. The bench provokes this by raising both strobes together on one entry. It expects the lookup to miss against the old, empty contents and a second lookup to hit on the new word. The permission checks can also coincide in one lookup. The bench sets kernel, write-protect and invalid flags on a single entry and clears the enables one at a time, so that each lower-priority vector appears only after the higher ones are disabled. Every expected fault steps a model LFSR in the bench, so each refill way and every hit that leaves `sel_reg` unchanged are judged against the exact fault history.

// File: rtl/tlbchk_pkg.sv
package tlbchk_pkg;
  localparam int WORD_W   = 32;
  localparam int PAGE_LSB = 13;
  localparam int VPN_W    = WORD_W - PAGE_LSB;
  localparam int PID_W    = 8;
  localparam int LFSR_W   = 16;

  // lower word flag positions
  localparam int LO_GLB = 4;
  localparam int LO_VLD = 3;
  localparam int LO_KRN = 2;
  localparam int LO_WR  = 1;
  localparam int LO_EX  = 0;

  // configuration enable positions
  localparam int EN_WR  = 19;
  localparam int EN_KRN = 18;
  localparam int EN_EX  = 17;
  localparam int EN_VLD = 16;

  localparam logic [3:0] VEC_IBASE = 4'd4;
  localparam logic [3:0] VEC_DBASE = 4'd8;

  typedef enum logic [1:0] {
    ACC_RD  = 2'd0,
    ACC_WR  = 2'd1,
    ACC_EX  = 2'd2,
    ACC_RSV = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    OFS_MISS  = 2'd0,
    OFS_INVAL = 2'd1,
    OFS_PRIV  = 2'd2,
    OFS_PROT  = 2'd3
  } vec_ofs_e;

  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s,
                                                   input logic [LFSR_W-1:0] taps);
    return {^(s & taps), s[LFSR_W-1:1]};
  endfunction

  function automatic logic [VPN_W-1:0] page_of(input logic [WORD_W-1:0] w);
    return w[WORD_W-1:PAGE_LSB];
  endfunction

  function automatic logic [WORD_W-1:0] cause_word(input logic [VPN_W-1:0] vpn,
                                                    input logic [1:0] acc,
                                                    input logic [PID_W-1:0] pid);
    logic [WORD_W-1:0] c;
    c = '0;
    c[WORD_W-1:PAGE_LSB] = vpn;
    c[9:8] = acc;
    c[PID_W-1:0] = pid;
    return c;
  endfunction
endpackage

// File: rtl/tlbchk_store.sv
module tlbchk_store #(
  parameter int WAYS = 4,
  parameter int SETS = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [$clog2(WAYS)-1:0]    wr_way,
  input  logic [$clog2(SETS)-1:0]    wr_idx,
  input  logic [31:0]                wr_hi,
  input  logic [31:0]                wr_lo,
  input  logic [$clog2(SETS)-1:0]    rd_idx,
  output logic [WAYS-1:0][31:0]      rd_hi,
  output logic [WAYS-1:0][31:0]      rd_lo
);
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [31:0] hi_q [SETS];
    logic [31:0] lo_q [SETS];
    logic        way_we;

    assign way_we = wr_en && (wr_way == w[$clog2(WAYS)-1:0]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < SETS; i++) begin
          hi_q[i] <= '0;
          lo_q[i] <= '0;
        end
      end else if (way_we) begin
        hi_q[wr_idx] <= wr_hi;
        lo_q[wr_idx] <= wr_lo;
      end
    end

    assign rd_hi[w] = hi_q[rd_idx];
    assign rd_lo[w] = lo_q[rd_idx];
  end
endmodule

// File: rtl/tlbchk_match.sv
module tlbchk_match
  import tlbchk_pkg::*;
#(
  parameter int WAYS = 4
) (
  input  logic [WAYS-1:0][31:0]    rd_hi,
  input  logic [WAYS-1:0][31:0]    rd_lo,
  input  logic [VPN_W-1:0]         vpn,
  input  logic [PID_W-1:0]         pid,
  output logic                     hit,
  output logic [$clog2(WAYS)-1:0]  hit_way,
  output logic [31:0]              hit_lo
);
  logic [WAYS-1:0] way_hit;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign way_hit[w] = (page_of(rd_hi[w]) == vpn) &&
                        (rd_lo[w][LO_GLB] || (rd_hi[w][PID_W-1:0] == pid));
  end

  // descending scan so the lowest matching way is the last assignment
  always_comb begin
    hit_way = '0;
    hit_lo  = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (way_hit[w]) begin
        hit_way = w[$clog2(WAYS)-1:0];
        hit_lo  = rd_lo[w];
      end
    end
  end

  assign hit = |way_hit;
endmodule

// File: rtl/tlbchk_prot.sv
module tlbchk_prot
  import tlbchk_pkg::*;
(
  input  logic [31:0] lo,
  input  logic [1:0]  acc,
  input  logic        user,
  input  logic [31:0] cfg,
  output logic        deny,
  output logic [1:0]  ofs
);
  logic krn_bad, wr_bad, ex_bad, vld_bad;

  assign krn_bad = cfg[EN_KRN] && lo[LO_KRN] && user;
  assign wr_bad  = cfg[EN_WR]  && (acc == ACC_WR) && !lo[LO_WR];
  assign ex_bad  = cfg[EN_EX]  && (acc == ACC_EX) && !lo[LO_EX];
  assign vld_bad = cfg[EN_VLD] && !lo[LO_VLD];

  always_comb begin
    deny = 1'b1;
    if (krn_bad)                ofs = OFS_PRIV;
    else if (wr_bad || ex_bad)  ofs = OFS_PROT;
    else if (vld_bad)           ofs = OFS_INVAL;
    else begin
      deny = 1'b0;
      ofs  = OFS_MISS;
    end
  end
endmodule

// File: rtl/tlbchk_lfsr.sv
module tlbchk_lfsr
  import tlbchk_pkg::*;
#(
  parameter logic [LFSR_W-1:0] SEED = 16'hCCCC,
  parameter logic [LFSR_W-1:0] TAPS = 16'h8805
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  output logic [LFSR_W-1:0] state
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   state <= SEED;
    else if (adv) state <= lfsr_step(state, TAPS);
  end
endmodule

// File: rtl/tlb_perm_checker.sv
module tlb_perm_checker
  import tlbchk_pkg::*;
#(
  parameter int WAYS = 4,
  parameter int SETS = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        wr_itlb,
  input  logic [1:0]  wr_way,
  input  logic [3:0]  wr_idx,
  input  logic [31:0] wr_hi,
  input  logic [31:0] wr_lo,
  input  logic [31:0] cfg,
  input  logic        req_vld,
  input  logic [31:0] req_vaddr,
  input  logic [1:0]  req_acc,
  input  logic        req_user,
  input  logic [7:0]  req_pid,
  output logic        rsp_vld,
  output logic        rsp_fault,
  output logic [3:0]  rsp_vec,
  output logic [31:0] rsp_paddr,
  output logic [3:0]  rsp_perm,
  output logic [5:0]  sel_reg,
  output logic [31:0] cause_reg
);
  localparam int WW = $clog2(WAYS);
  localparam int IW = $clog2(SETS);
  localparam int NTLB = 2; // 0 instruction, 1 data

  logic [IW-1:0]         look_idx;
  logic [VPN_W-1:0]      look_vpn;
  logic                  use_itlb;
  logic [1:0]            acc_rep;
  logic [NTLB-1:0][WAYS-1:0][31:0] bank_hi, bank_lo;
  logic [WAYS-1:0][31:0] sel_hi, sel_lo;
  logic                  hit;
  logic [WW-1:0]         hit_way;
  logic [31:0]           hit_lo;
  logic                  deny;
  logic [1:0]            deny_ofs;
  logic [LFSR_W-1:0]     lfsr_q;
  logic                  miss_evt, fault_evt;
  logic [3:0]            vec_base, vec_now;
  logic [WW-1:0]         fault_way;

  assign look_idx = req_vaddr[PAGE_LSB +: IW];
  assign look_vpn = page_of(req_vaddr);
  assign use_itlb = (req_acc == ACC_EX);
  assign acc_rep  = (req_acc == ACC_RSV) ? ACC_RD : req_acc;

  for (genvar m = 0; m < NTLB; m++) begin : g_tlb
    logic bank_we;
    assign bank_we = wr_en && (wr_itlb == (m == 0));
    tlbchk_store #(.WAYS(WAYS), .SETS(SETS)) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (bank_we),
      .wr_way (wr_way[WW-1:0]),
      .wr_idx (wr_idx[IW-1:0]),
      .wr_hi  (wr_hi),
      .wr_lo  (wr_lo),
      .rd_idx (look_idx),
      .rd_hi  (bank_hi[m]),
      .rd_lo  (bank_lo[m])
    );
  end

  assign sel_hi = use_itlb ? bank_hi[0] : bank_hi[1];
  assign sel_lo = use_itlb ? bank_lo[0] : bank_lo[1];

  tlbchk_match #(.WAYS(WAYS)) u_match (
    .rd_hi   (sel_hi),
    .rd_lo   (sel_lo),
    .vpn     (look_vpn),
    .pid     (req_pid),
    .hit     (hit),
    .hit_way (hit_way),
    .hit_lo  (hit_lo)
  );

  tlbchk_prot u_prot (
    .lo   (hit_lo),
    .acc  (req_acc),
    .user (req_user),
    .cfg  (cfg),
    .deny (deny),
    .ofs  (deny_ofs)
  );

  assign miss_evt  = req_vld && !hit;
  assign fault_evt = req_vld && (!hit || deny);

  tlbchk_lfsr u_lfsr (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (fault_evt),
    .state (lfsr_q)
  );

  assign vec_base  = use_itlb ? VEC_IBASE : VEC_DBASE;
  assign vec_now   = vec_base + {2'b00, (hit ? deny_ofs : OFS_MISS)};
  assign fault_way = hit ? hit_way : lfsr_q[WW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_vld   <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_vec   <= '0;
      rsp_paddr <= '0;
      rsp_perm  <= '0;
      sel_reg   <= '0;
      cause_reg <= '0;
    end else begin
      rsp_vld <= req_vld;
      if (req_vld) begin
        rsp_fault <= fault_evt;
        rsp_vec   <= fault_evt ? vec_now : 4'd0;
        rsp_paddr <= fault_evt ? 32'd0 : {page_of(hit_lo), req_vaddr[PAGE_LSB-1:0]};
        rsp_perm  <= fault_evt ? 4'd0 : hit_lo[3:0];
      end
      if (fault_evt) begin
        sel_reg   <= '0;
        sel_reg[3:0] <= 4'(look_idx);
        sel_reg[5:4] <= 2'(fault_way);
        cause_reg <= cause_word(look_vpn, acc_rep, req_pid);
      end
    end
  end
endmodule

// File: rtl/tlbchk_sva.sv
module tlbchk_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        req_vld,
  input logic [31:0] req_vaddr,
  input logic [1:0]  req_acc,
  input logic        rsp_vld,
  input logic        rsp_fault,
  input logic [3:0]  rsp_vec,
  input logic [31:0] rsp_paddr,
  input logic [5:0]  sel_reg,
  input logic [31:0] cause_reg,
  input logic [15:0] lfsr_q,
  input logic        miss_evt,
  input logic        fault_evt
);
  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |=> rsp_vld); // R3
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld |=> !rsp_vld); // R3
  AST_PAGE_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |=> (rsp_fault || rsp_paddr[12:0] == $past(req_vaddr[12:0]))); // R3
  AST_VEC_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |=> (!rsp_fault ||
                 rsp_vec[3:2] == (($past(req_acc) == 2'd2) ? 2'd1 : 2'd2))); // R7
  AST_MISS_VEC_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    miss_evt |=> (rsp_fault && rsp_vec[1:0] == 2'd0)); // R7
  AST_LFSR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_evt |=> $stable(lfsr_q)); // R8
  AST_LFSR_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    fault_evt |=> lfsr_q != $past(lfsr_q)); // R8
  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != 16'd0); // R8
  AST_REFILL_WAY: assert property (@(posedge clk) disable iff (!rst_n)
    miss_evt |=> sel_reg[5:4] == $past(lfsr_q[1:0])); // R8
  AST_SEL_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    fault_evt |=> sel_reg[3:0] == $past(req_vaddr[16:13])); // R9
  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_evt |=> $stable(sel_reg)); // R9
  AST_CAUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_evt |=> $stable(cause_reg)); // R10
  AST_CAUSE_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    fault_evt |=> cause_reg[31:13] == $past(req_vaddr[31:13])); // R10
endmodule

bind tlb_perm_checker tlbchk_sva u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_vld   (req_vld),
  .req_vaddr (req_vaddr),
  .req_acc   (req_acc),
  .rsp_vld   (rsp_vld),
  .rsp_fault (rsp_fault),
  .rsp_vec   (rsp_vec),
  .rsp_paddr (rsp_paddr),
  .sel_reg   (sel_reg),
  .cause_reg (cause_reg),
  .lfsr_q    (lfsr_q),
  .miss_evt  (miss_evt),
  .fault_evt (fault_evt)
);

// File: tb/tlb_perm_checker_tb.sv
module tlb_perm_checker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_itlb = 1'b0;
  logic [1:0]  wr_way = '0;
  logic [3:0]  wr_idx = '0;
  logic [31:0] wr_hi = '0, wr_lo = '0, cfg = '0;
  logic        req_vld = 1'b0, req_user = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_acc = '0;
  logic [7:0]  req_pid = '0;
  logic        rsp_vld, rsp_fault;
  logic [3:0]  rsp_vec, rsp_perm;
  logic [31:0] rsp_paddr, cause_reg;
  logic [5:0]  sel_reg;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  logic [15:0] m_lfsr = 16'hCCCC;
  logic [5:0]  last_sel = '0;

  localparam logic [31:0] CFG_ALL = 32'h000F_0000;

  always #10 clk = ~clk; // 50 MHz

  tlb_perm_checker dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_itlb(wr_itlb), .wr_way(wr_way),
    .wr_idx(wr_idx), .wr_hi(wr_hi), .wr_lo(wr_lo), .cfg(cfg), .req_vld(req_vld),
    .req_vaddr(req_vaddr), .req_acc(req_acc), .req_user(req_user), .req_pid(req_pid),
    .rsp_vld(rsp_vld), .rsp_fault(rsp_fault), .rsp_vec(rsp_vec), .rsp_paddr(rsp_paddr),
    .rsp_perm(rsp_perm), .sel_reg(sel_reg), .cause_reg(cause_reg)
  );

  function automatic logic [15:0] model_next(input logic [15:0] s);
    int ones = 0;
    logic [15:0] masked = s & 16'h8805;
    for (int b = 0; b < 16; b++) ones += masked[b];
    return (s >> 1) | (16'(ones % 2) << 15);
  endfunction

  function automatic logic [31:0] hi_w(input logic [18:0] vpn, input logic [7:0] pid);
    return (32'(vpn) << 13) | 32'(pid);
  endfunction

  // g v k w x
  function automatic logic [31:0] lo_w(input logic [18:0] pfn, input logic [4:0] flags);
    return (32'(pfn) << 13) | 32'(flags);
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic put_entry(input bit itlb, input int way, input int idx,
                           input logic [31:0] hi, input logic [31:0] lo);
    @(negedge clk);
    wr_en = 1; wr_itlb = itlb; wr_way = 2'(way); wr_idx = 4'(idx); wr_hi = hi; wr_lo = lo;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic lookup(input logic [31:0] va, input int acc, input bit user,
                        input logic [7:0] pid);
    @(negedge clk);
    req_vld = 1; req_vaddr = va; req_acc = 2'(acc); req_user = user; req_pid = pid;
    @(posedge clk); #1;
    req_vld = 0;
  endtask

  task automatic expect_hit(input string req, input logic [31:0] pa, input logic [3:0] perm);
    check(req, "rsp_vld", 32'(rsp_vld), 1);
    check(req, "fault", 32'(rsp_fault), 0);
    check(req, "paddr", rsp_paddr, pa);
    check(req, "perm", 32'(rsp_perm), 32'(perm));
    check(req, "sel held", 32'(sel_reg), 32'(last_sel));
  endtask

  task automatic expect_fault(input string req, input int vec, input bit miss, input int way,
                              input logic [31:0] va, input int acc, input logic [7:0] pid);
    int w;
    w = miss ? int'(m_lfsr[1:0]) : way;
    check(req, "fault", 32'(rsp_fault), 1);
    check(req, "vec", 32'(rsp_vec), 32'(vec));
    check(req, "sel", 32'(sel_reg), 32'(w * 16 + int'(va[16:13])));
    check(req, "cause", cause_reg, (va & 32'hFFFF_E000) | (32'(acc) << 8) | 32'(pid));
    m_lfsr = model_next(m_lfsr);
    last_sel = sel_reg;
  endtask

  task automatic t_reset();
    check("R11", "rsp_vld", 32'(rsp_vld), 0);
    check("R11", "sel", 32'(sel_reg), 0);
    check("R11", "cause", cause_reg, 0);
    cfg = 0;
    lookup(32'h0000_0ABC, 0, 0, 8'h00); // zeroed entry: vpn 0 pid 0
    expect_hit("R11", 32'h0000_0ABC, 4'h0);
  endtask

  task automatic t_basic();
    cfg = CFG_ALL;
    put_entry(0, 2, 5, hi_w(19'h12345, 8'h3A), lo_w(19'h0ABCD, 5'b01010));
    lookup({19'h12345, 13'h0123}, 0, 1, 8'h3A);
    expect_hit("R3", {19'h0ABCD, 13'h0123}, 4'b1010);
    lookup({19'h12345, 13'h1FFF}, 3, 1, 8'h3A);
    expect_hit("R2", {19'h0ABCD, 13'h1FFF}, 4'b1010);
    lookup({19'h12345, 13'h0010}, 0, 1, 8'h3B); // wrong pid
    expect_fault("R2", 8, 1, 0, {19'h12345, 13'h0010}, 0, 8'h3B);
    lookup({19'h12345, 13'h0010}, 2, 0, 8'h3A); // exec goes to instruction buffer
    expect_fault("R7", 4, 1, 0, {19'h12345, 13'h0010}, 2, 8'h3A);
  endtask

  task automatic t_global();
    put_entry(1, 1, 7, hi_w(19'h00017, 8'h55), lo_w(19'h00777, 5'b11001));
    lookup({19'h00017, 13'h0042}, 2, 1, 8'h99);
    expect_hit("R2", {19'h00777, 13'h0042}, 4'b1001);
  endtask

  task automatic t_lowest();
    put_entry(0, 3, 9, hi_w(19'h40009, 8'h3A), lo_w(19'h00333, 5'b01110));
    put_entry(0, 1, 9, hi_w(19'h40009, 8'h3A), lo_w(19'h00111, 5'b01010));
    lookup({19'h40009, 13'h0004}, 1, 0, 8'h3A);
    expect_hit("R4", {19'h00111, 13'h0004}, 4'b1010);
  endtask

  task automatic t_priority();
    logic [31:0] va = {19'h40009, 13'h0008};
    put_entry(0, 1, 9, hi_w(19'h40009, 8'h3A), lo_w(19'h00111, 5'b00100)); // k, !w, !v
    cfg = CFG_ALL;
    lookup(va, 1, 1, 8'h3A);
    expect_fault("R5", 10, 0, 1, va, 1, 8'h3A);
    lookup(va, 1, 0, 8'h3A);
    expect_fault("R5", 11, 0, 1, va, 1, 8'h3A);
    lookup(va, 0, 0, 8'h3A);
    expect_fault("R5", 9, 0, 1, va, 0, 8'h3A);
    cfg = 32'h0007_0000; // write check off
    lookup(va, 1, 0, 8'h3A);
    expect_fault("R6", 9, 0, 1, va, 1, 8'h3A);
    cfg = 32'h0004_0000; // kernel only
    lookup(va, 1, 1, 8'h3A);
    expect_fault("R6", 10, 0, 1, va, 1, 8'h3A);
    cfg = 0;
    lookup(va, 1, 1, 8'h3A);
    expect_hit("R6", {19'h00111, 13'h0008}, 4'b0100);
    put_entry(1, 0, 3, hi_w(19'h00023, 8'h3A), lo_w(19'h00222, 5'b00000)); // !x !v
    va = {19'h00023, 13'h0100};
    cfg = CFG_ALL;
    lookup(va, 2, 0, 8'h3A);
    expect_fault("R5", 7, 0, 0, va, 2, 8'h3A);
    cfg = 32'h000D_0000; // exec check off
    lookup(va, 2, 0, 8'h3A);
    expect_fault("R6", 5, 0, 0, va, 2, 8'h3A);
  endtask

  task automatic t_refill();
    cfg = CFG_ALL;
    for (int k = 0; k < 6; k++) begin
      logic [31:0] va = {19'h7FF00 + 19'(k), 13'h0};
      lookup(va, 1, 0, 8'h21);
      expect_fault("R8", 8, 1, 0, va, 1, 8'h21);
    end
    lookup({19'h00017, 13'h0}, 2, 0, 8'h01); // hit: lfsr must hold
    expect_hit("R9", {19'h00777, 13'h0}, 4'b1001);
    lookup({19'h7FF10, 13'h0}, 0, 0, 8'h21);
    expect_fault("R10", 8, 1, 0, {19'h7FF10, 13'h0}, 0, 8'h21);
  endtask

  task automatic t_collide();
    logic [31:0] va = {19'h0000C, 13'h0055};
    cfg = CFG_ALL;
    @(negedge clk);
    wr_en = 1; wr_itlb = 0; wr_way = 0; wr_idx = 4'hC;
    wr_hi = hi_w(19'h0000C, 8'h01); wr_lo = lo_w(19'h00ACE, 5'b01011);
    req_vld = 1; req_vaddr = va; req_acc = 0; req_user = 0; req_pid = 8'h01;
    @(posedge clk); #1;
    req_vld = 0; wr_en = 0;
    expect_fault("R1", 8, 1, 0, va, 0, 8'h01);
    lookup(va, 0, 0, 8'h01);
    expect_hit("R1", {19'h00ACE, 13'h0055}, 4'b1011);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    t_reset();
    t_basic();
    t_global();
    t_lowest();
    t_priority();
    t_refill();
    t_collide();
    repeat (2) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule